// File: doc/BRIEF.md
# Frame-Tagging Transmit FIFO Controller

This block is a transmit queue that sits between a bus master filling it and a peripheral draining it. Every stored word carries two tag bits next to its data. One tag marks the word as control information for the peripheral. The other marks it as the last word of a frame. Software sets these tags ahead of time by raising one-shot arm bits in a control register. Each arm bit applies to exactly one accepted data word and then clears itself.

The block drives an alarm request that tells a DMA engine to keep supplying words. The alarm is held while the free space in the queue is at or above a programmable threshold. In frame mode the block counts the complete frames it holds and raises a frame-ready status. While a frame is ready, that status replaces the threshold as the point where the alarm stops.

Both data paths use valid/ready:
- **Write side.** A word is accepted on a clock edge where `wr_valid` and `wr_ready` are both high. Holding `wr_valid` high while `wr_ready` is low is an error: the word is dropped and a sticky overflow flag is set.
- **Read side.** The read side is first-word-fall-through. `rd_data` and the tags show the oldest word whenever `rd_valid` is high, and `rd_ready` pops that word. Raising `rd_ready` while `rd_valid` is low is an error that sets a sticky underflow flag.

Both sticky flags clear only on reset.

Top module: `txq_frame_ctrl`

## Requirements
- R1: When the control-arm bit (control register bit 0) is 1, the next accepted data word is stored with its control tag set, and `rd_is_ctrl` is 1 while that word is at the head of the queue. Words stored while the bit is 0 have the tag clear.
- R2: On the edge that accepts a data word, both arm bits (bit 0 control, bit 1 end-of-frame) clear, unless a register write happens on the same edge, in which case the written value wins. A dropped word does not clear them. `cfg_rdata` always shows the register: bit 0 control arm, bit 1 end-of-frame arm, bit 2 frame-mode enable, bits 8 and up (log2(DEPTH)+1 bits wide) the alarm threshold, and all other bits 0.
- R3: With frame mode enabled (bit 2 = 1), the end-of-frame arm bit tags the next accepted word as the end of a frame, and `rd_is_eof` is 1 while that word is at the head.
- R4: With frame mode disabled, the end-of-frame arm bit has no effect on the stored tag: the word reads back with `rd_is_eof` = 0, and `frame_ready` stays 0.
- R5: Words leave in the order they were accepted, with their data unchanged. `rd_valid` is 1 exactly when the queue holds at least one word.
- R6: `wr_ready` is 0 exactly when the queue holds DEPTH words. A word offered while full is dropped and sets `overflow`, which stays 1 until reset.
- R7: Raising `rd_ready` while the queue is empty removes nothing and sets `underflow`, which stays 1 until reset.
- R8: With frame mode off, `alarm` is 1 exactly when the free space (DEPTH minus occupancy) is greater than or equal to the threshold field.
- R9: A frame count rises when an end-of-frame-tagged word is accepted and falls when one is popped. `frame_ready` is 1 exactly when frame mode is on and the count is nonzero.
- R10: With frame mode on, `alarm` is 1 exactly when free space is at or above the threshold and `frame_ready` is 0.
- R11: Bit 31 of the control register always reads 0, even when software writes 1 to it.
- R12: After reset the queue is empty, both arm bits and frame mode are 0, the threshold is GRAN_RST, `overflow`, `underflow` and `frame_ready` are 0, `wr_ready` is 1, and `alarm` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write value |
| cfg_rdata | output | 32 | Control register current value |
| wr_valid | input | 1 | Write side: word offered |
| wr_ready | output | 1 | Write side: space available |
| wr_data | input | DW | Write side: data word |
| rd_valid | output | 1 | Read side: head word present |
| rd_ready | input | 1 | Read side: pop head word |
| rd_data | output | DW | Read side: head data |
| rd_is_ctrl | output | 1 | Head word is control information |
| rd_is_eof | output | 1 | Head word ends a frame |
| alarm | output | 1 | Request for more data |
| frame_ready | output | 1 | A complete frame is buffered (frame mode) |
| overflow | output | 1 | Sticky: word offered while full |
| underflow | output | 1 | Sticky: pop requested while empty |

## Verification
The in-line assertions are checked on every cycle. They cover these invariants:
- Occupancy never passes DEPTH, and an offer made while full leaves the queue full.
- Both error flags are sticky.
- The arm bits clear after an accepted word.
- The frame count never exceeds occupancy.
- The alarm is never high while a frame is ready.

The exact tag, data and order of each word (R1, R3, R4, R5) can only be shown by the bench's scenarios. The same holds for the threshold arithmetic of the alarm and the register read-back layout with its reserved bit. The bench compares each of these against a queue model under directed and random traffic.

// File: rtl/txq_pkg.sv
package txq_pkg;
  // tag pair stored next to each data word
  typedef struct packed {
    logic ctrl;
    logic eof;
  } tag_t;

  // control register field positions (bit 31 is reserved)
  localparam int ARM_CTRL_BIT = 0;
  localparam int ARM_EOF_BIT  = 1;
  localparam int FRM_EN_BIT   = 2;
  localparam int GRAN_LSB     = 8;
endpackage

// File: rtl/txq_ctl_regs.sv
module txq_ctl_regs #(
  parameter int GW       = 5,
  parameter int GRAN_RST = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [31:0]   cfg_wdata,
  input  logic          wr_fire,
  output logic [31:0]   cfg_rdata,
  output logic          ctrl_arm,
  output logic          eof_arm,
  output logic          fm_en,
  output logic [GW-1:0] gran
);
  import txq_pkg::*;

  localparam int GHI = GRAN_LSB + GW;

  logic unused_wdata;
  assign unused_wdata = ^{cfg_wdata[31:GHI], cfg_wdata[GRAN_LSB-1:FRM_EN_BIT+1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_arm <= 1'b0;
      eof_arm  <= 1'b0;
      fm_en    <= 1'b0;
      gran     <= GW'(GRAN_RST);
    end else if (cfg_we) begin
      ctrl_arm <= cfg_wdata[ARM_CTRL_BIT];
      eof_arm  <= cfg_wdata[ARM_EOF_BIT];
      fm_en    <= cfg_wdata[FRM_EN_BIT];
      gran     <= cfg_wdata[GRAN_LSB +: GW];
    end else if (wr_fire) begin
      ctrl_arm <= 1'b0;
      eof_arm  <= 1'b0;
    end
  end

  always_comb begin
    cfg_rdata               = '0;
    cfg_rdata[ARM_CTRL_BIT] = ctrl_arm;
    cfg_rdata[ARM_EOF_BIT]  = eof_arm;
    cfg_rdata[FRM_EN_BIT]   = fm_en;
    cfg_rdata[GRAN_LSB +: GW] = gran;
  end

  // R2
  arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !cfg_we) |=> (!ctrl_arm && !eof_arm));
endmodule

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  input  logic [DW-1:0]            wr_data,
  input  txq_pkg::tag_t            wr_tag,
  output logic                     wr_ready,
  input  logic                     rd_ready,
  output logic                     rd_valid,
  output logic [DW-1:0]            rd_data,
  output txq_pkg::tag_t            rd_tag,
  output logic [$clog2(DEPTH):0]   occ,
  output logic                     push,
  output logic                     pop,
  output logic                     overflow,
  output logic                     underflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = DW + 2;
  localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, empty;

  assign full     = (occ == DEPTH_L);
  assign empty    = (occ == '0);
  assign wr_ready = !full;
  assign rd_valid = !empty;
  assign push     = wr_valid && !full;
  assign pop      = rd_ready && !empty;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {wr_tag, wr_data};
  end

  assign rd_data = mem[rp][DW-1:0];
  assign rd_tag  = mem[rp][EW-1:DW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp        <= '0;
      rp        <= '0;
      occ       <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      if (push && !pop)      occ <= occ + 1'b1;
      else if (pop && !push) occ <= occ - 1'b1;
      if (wr_valid && full)  overflow  <= 1'b1;
      if (rd_ready && empty) underflow <= 1'b1;
    end
  end

  // R6
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= DEPTH_L);
  // R6
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && full && !rd_ready) |=> (occ == DEPTH_L));
  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R7
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
endmodule

// File: rtl/txq_frame_track.sv
module txq_frame_track #(
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push,
  input  logic                   push_eof,
  input  logic                   pop,
  input  logic                   pop_eof,
  input  logic                   fm_en,
  input  logic [$clog2(DEPTH):0] gran,
  input  logic [$clog2(DEPTH):0] occ,
  output logic                   frame_ready,
  output logic                   alarm
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);

  logic [AW:0] fcnt;
  logic [AW:0] free_sp;
  logic        inc, dec;

  assign inc = push && push_eof;
  assign dec = pop && pop_eof;

  always_ff @(posedge clk) begin
    if (!rst_n)          fcnt <= '0;
    else if (inc && !dec) fcnt <= fcnt + 1'b1;
    else if (dec && !inc) fcnt <= fcnt - 1'b1;
  end

  assign free_sp     = DEPTH_L - occ;
  assign frame_ready = fm_en && (fcnt != '0);
  assign alarm       = (free_sp >= gran) && !frame_ready;

  // R9
  fcnt_le_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= occ);
  // R10
  alarm_vs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |-> !frame_ready);
endmodule

// File: rtl/txq_frame_ctrl.sv
module txq_frame_ctrl #(
  parameter int DW       = 32,
  parameter int DEPTH    = 16,
  parameter int GRAN_RST = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_is_ctrl,
  output logic          rd_is_eof,
  output logic          alarm,
  output logic          frame_ready,
  output logic          overflow,
  output logic          underflow
);
  import txq_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int GW = AW + 1;

  logic          ctrl_arm, eof_arm, fm_en;
  logic [GW-1:0] gran;
  logic [AW:0]   occ;
  logic          push, pop;
  tag_t          wtag, rtag;

  assign wtag.ctrl = ctrl_arm;
  assign wtag.eof  = eof_arm && fm_en;   // R4: end-of-frame arm gated by frame mode

  txq_ctl_regs #(.GW(GW), .GRAN_RST(GRAN_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .wr_fire(push), .cfg_rdata(cfg_rdata), .ctrl_arm(ctrl_arm),
    .eof_arm(eof_arm), .fm_en(fm_en), .gran(gran)
  );

  txq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_tag(wtag), .wr_ready(wr_ready), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_tag(rtag), .occ(occ),
    .push(push), .pop(pop), .overflow(overflow), .underflow(underflow)
  );

  txq_frame_track #(.DEPTH(DEPTH)) u_frame (
    .clk(clk), .rst_n(rst_n), .push(push), .push_eof(wtag.eof),
    .pop(pop), .pop_eof(rtag.eof), .fm_en(fm_en), .gran(gran), .occ(occ),
    .frame_ready(frame_ready), .alarm(alarm)
  );

  assign rd_is_ctrl = rtag.ctrl;
  assign rd_is_eof  = rtag.eof;
endmodule

// File: tb/tb_txq_frame_ctrl.sv
`timescale 1ns/1ps
module tb_txq_frame_ctrl;
  localparam int DW = 32;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0; logic [31:0] cfg_wdata = '0; logic [31:0] cfg_rdata;
  logic wr_valid = 1'b0; logic wr_ready; logic [DW-1:0] wr_data = '0;
  logic rd_valid; logic rd_ready = 1'b0; logic [DW-1:0] rd_data;
  logic rd_is_ctrl, rd_is_eof, alarm, frame_ready, overflow, underflow;

  always #2 clk = ~clk;

  txq_frame_ctrl #(.DW(DW), .DEPTH(DEPTH), .GRAN_RST(4)) dut (.*);

  int total = 0, bad = 0;
  bit done = 0;

  // model state
  logic [DW+1:0] q[$];
  bit m_ctrl_arm, m_eof_arm, m_fm, m_ovf, m_unf;
  int m_gran, m_fcnt;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_cfg();
    return {19'd0, 5'(m_gran), 5'd0, m_fm, m_eof_arm, m_ctrl_arm};
  endfunction

  function automatic bit exp_alarm();
    return ((DEPTH - q.size()) >= m_gran) && !(m_fm && m_fcnt != 0);
  endfunction

  task automatic check_all();
    chk("R5 rd_valid", rd_valid, q.size() != 0);
    if (q.size() != 0) begin
      chk("R5 rd_data", rd_data, q[0][DW-1:0]);
      chk("R1 rd_is_ctrl", rd_is_ctrl, q[0][DW+1]);
      chk(m_fm ? "R3 rd_is_eof" : "R4 rd_is_eof", rd_is_eof, q[0][DW]);
    end
    chk("R6 wr_ready", wr_ready, q.size() < DEPTH);
    chk("R6 overflow", overflow, m_ovf);
    chk("R7 underflow", underflow, m_unf);
    chk("R2 cfg_rdata", {1'b0, cfg_rdata[30:0]}, exp_cfg());
    chk("R11 reserved bit", cfg_rdata[31], 0);
    chk(m_fm ? "R9 frame_ready" : "R4 frame_ready", frame_ready, m_fm && m_fcnt != 0);
    chk(m_fm ? "R10 alarm" : "R8 alarm", alarm, exp_alarm());
  endtask

  task automatic step(input bit cwe, input logic [31:0] cwd, input bit wv,
                      input logic [DW-1:0] wd, input bit rr);
    bit full, empty, push, pop;
    logic [DW+1:0] e;
    @(negedge clk);
    check_all();
    cfg_we = cwe; cfg_wdata = cwd; wr_valid = wv; wr_data = wd; rd_ready = rr;
    full = (q.size() == DEPTH); empty = (q.size() == 0);
    push = wv && !full; pop = rr && !empty;
    if (wv && full) m_ovf = 1;
    if (rr && empty) m_unf = 1;
    if (pop) begin
      e = q.pop_front();
      if (e[DW]) m_fcnt--;
    end
    if (push) begin
      q.push_back({m_ctrl_arm, m_eof_arm && m_fm, wd});
      if (m_eof_arm && m_fm) m_fcnt++;
    end
    if (cwe) begin
      m_ctrl_arm = cwd[0]; m_eof_arm = cwd[1]; m_fm = cwd[2];
      m_gran = int'(cwd[12:8]);
    end else if (push) begin
      m_ctrl_arm = 0; m_eof_arm = 0;
    end
  endtask

  task automatic cfgw(input logic [31:0] v); step(1, v, 0, '0, 0); endtask
  task automatic wr(input logic [DW-1:0] d); step(0, '0, 1, d, 0); endtask
  task automatic rd(); step(0, '0, 0, '0, 1); endtask
  task automatic idle(); step(0, '0, 0, '0, 0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_gran = 4; m_fcnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R12 reset state
    chk("R12 rd_valid", rd_valid, 0);
    chk("R12 wr_ready", wr_ready, 1);
    chk("R12 cfg_rdata", cfg_rdata, 32'h0000_0400);
    chk("R12 alarm", alarm, 1);
    chk("R12 frame_ready", frame_ready, 0);
    chk("R12 flags", {overflow, underflow}, 0);

    // R1/R2: control tag on one word only
    cfgw(32'h0000_0401); wr(32'hA0A0_0001); wr(32'hB0B0_0002); rd(); rd(); idle();
    // R3/R9/R10: frame mode end-of-frame tagging
    cfgw(32'h0000_0404); wr(32'h1111_0001); cfgw(32'h0000_0406);
    wr(32'h1111_0002); idle(); wr(32'h1111_0003); rd(); rd(); idle(); rd(); idle();
    // R4: end-of-frame arm without frame mode
    cfgw(32'h0000_0402); wr(32'h2222_0001); idle(); rd(); idle();
    // R8: threshold at free space 8
    cfgw(32'h0000_0800);
    for (int i = 0; i < 10; i++) wr(32'h3000_0000 + i);
    for (int i = 0; i < 10; i++) rd();
    // R11: reserved bit written as 1
    cfgw(32'h8000_0400); idle();
    // R2: register write and data write on one edge, written value wins
    step(1, 32'h0000_0401, 1, 32'h4444_0001, 0); wr(32'h4444_0002); rd(); rd();
    // R7: pop while empty
    rd(); idle();
    // R6: fill past full
    for (int i = 0; i < DEPTH + 2; i++) wr(32'h5000_0000 + i);
    for (int i = 0; i < DEPTH; i++) rd();
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      bit cwe;
      cwe = ($urandom % 16) == 0;
      step(cwe, $urandom, ($urandom % 10) < 6, $urandom, ($urandom % 2) == 1);
    end
    step(0, '0, 0, '0, 0);
    @(negedge clk); check_all();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule